// File: doc/BRIEF.md
# Dual-Issue Latency-Aware Issue Scoreboard

This block is the hazard check at the issue stage of an in-order, statically scheduled, dual-issue SIMD core. Each cycle it is offered two decoded instructions. Slot 0 is the older one and slot 1 the younger. Each instruction carries a class code, an optional destination and up to three optional sources. All indices point into one shared register file, which holds both scalar and vector data, so there are no transfers between separate files to account for. The block drives one grant per slot.

A small countdown is kept for every register. When an instruction issues, the countdown of its destination is loaded from the producer class's fixed latency. A source may be consumed once that countdown has drained to zero, which is the cycle its value can be forwarded. The classes are spread over two pipes. Fixed-point and floating-point work goes to the even pipe. Permute, load/store, branch and channel work goes to the odd pipe. A pair issues together only when it fills both pipes in the order even then odd. Two writes to the same register must complete in program order. Nothing passes anything: a stalled older slot also holds the younger one.

Top module: `issue_scoreboard`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, both grants are low. After it is released, every register counts as ready.
- R2: At most two instructions issue per cycle. `issue1` is never high unless `issue0` is high in the same cycle. If slot 0 is not valid, nothing issues.
- R3: Class codes on the 3-bit class inputs are: 0 fixed point, 1 floating point, 2 permute, 3 load/store, 4 branch, 5 channel. Codes 6 and 7 behave as channel. Codes 0 and 1 use the even pipe; all others use the odd pipe.
- R4: A producer that issues in cycle t makes its destination readable from cycle t+L. L is 2 for fixed point, 4 for permute, 6 for load/store and floating point, and 2 for branch and channel. An instruction whose valid source names a register that is not yet readable does not issue.
- R5: Both slots issue together only when slot 0 is an even-pipe class and slot 1 is an odd-pipe class. Otherwise at most slot 0 issues.
- R6: Slot 1 does not issue with slot 0 if slot 1 has a valid source equal to slot 0's valid destination. It also does not issue with slot 0 if both slots have valid destinations that are equal.
- R7: When slot 0 cannot issue, slot 1 does not issue, even if slot 1 is free of hazards.
- R8: A write to a register that an earlier instruction is still producing issues only if it finishes strictly later. Its issue cycle plus its latency must exceed the older producer's issue cycle plus the older producer's latency.
- R9: Sources whose valid bit is low never stall. A destination whose valid bit is low leaves the scoreboard unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0Valid | input | 1 | Slot 0 (older) holds an instruction |
| in0Class | input | 3 | Slot 0 class code |
| in0DstValid | input | 1 | Slot 0 writes a register |
| in0Dst | input | 7 | Slot 0 destination index |
| in0SrcValid | input | 3 | Slot 0 per-source valid bits, bit k for source k |
| in0Srcs | input | 21 | Slot 0 sources, source k in bits [7k+6:7k] |
| in1Valid | input | 1 | Slot 1 (younger) holds an instruction |
| in1Class | input | 3 | Slot 1 class code |
| in1DstValid | input | 1 | Slot 1 writes a register |
| in1Dst | input | 7 | Slot 1 destination index |
| in1SrcValid | input | 3 | Slot 1 per-source valid bits |
| in1Srcs | input | 21 | Slot 1 sources, same packing as slot 0 |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |

## Verification
The checker tests a set of rules on every cycle:
- the slot ordering and the quiet reset;
- the even-then-odd pipe rule for a pair;
- independence within a pair;
- no consumer issuing in the cycle right after its producer;
- back-to-back writers to one register ending in order.

Some behaviours depend on how far a countdown has drained, so only the bench's scenarios can show them. These are the exact cycle on which a stalled consumer is released for each latency class, and the release of a write-after-write stall several cycles later. The bench also shows that stalls are not caused by invalid sources or by invalid destinations.

// File: rtl/issue_sb_pkg.sv
package issue_sb_pkg;

  localparam int NUM_SRCS = 3;
  localparam int MAX_LAT  = 6;
  localparam int CNT_W    = $clog2(MAX_LAT + 1);
  localparam int CLS_W    = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_FIX  = 3'd0,
    CLS_FLT  = 3'd1,
    CLS_PERM = 3'd2,
    CLS_LDST = 3'd3,
    CLS_BRCH = 3'd4,
    CLS_CHAN = 3'd5
  } instClass_t;

  // strobes from control to the countdown array
  typedef struct packed {
    logic             load0;
    logic [CNT_W-1:0] init0;
    logic             load1;
    logic [CNT_W-1:0] init1;
  } sbStrobe_t;

  function automatic logic [CNT_W-1:0] classLatency(input logic [CLS_W-1:0] cls);
    case (cls)
      CLS_FIX:  classLatency = CNT_W'(2);
      CLS_FLT:  classLatency = CNT_W'(6);
      CLS_PERM: classLatency = CNT_W'(4);
      CLS_LDST: classLatency = CNT_W'(6);
      default:  classLatency = CNT_W'(2);
    endcase
  endfunction

  function automatic logic isEvenPipe(input logic [CLS_W-1:0] cls);
    isEvenPipe = (cls == CLS_FIX) || (cls == CLS_FLT);
  endfunction

endpackage

// File: rtl/sb_countdown.sv
module sb_countdown
  import issue_sb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int NUM_RD   = 8,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  sbStrobe_t        strobe,
  input  logic [REG_W-1:0] wrIdx0,
  input  logic [REG_W-1:0] wrIdx1,
  input  logic [REG_W-1:0] rdIdx [NUM_RD],
  output logic [CNT_W-1:0] rdCnt [NUM_RD]
);

  logic [CNT_W-1:0] remaining [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        remaining[r] <= '0;
      end else if (strobe.load0 && wrIdx0 == REG_W'(r)) begin
        remaining[r] <= strobe.init0;
      end else if (strobe.load1 && wrIdx1 == REG_W'(r)) begin
        remaining[r] <= strobe.init1;
      end else if (remaining[r] != '0) begin
        remaining[r] <= remaining[r] - CNT_W'(1);
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdCnt[p] = remaining[rdIdx[p]];
  end

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import issue_sb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int NUM_RD  = 2 * (NUM_SRCS + 1)
) (
  input  logic                      rst,
  input  logic                      in0Valid,
  input  logic [CLS_W-1:0]          in0Class,
  input  logic                      in0DstValid,
  input  logic [REG_W-1:0]          in0Dst,
  input  logic [NUM_SRCS-1:0]       in0SrcValid,
  input  logic [NUM_SRCS*REG_W-1:0] in0Srcs,
  input  logic                      in1Valid,
  input  logic [CLS_W-1:0]          in1Class,
  input  logic                      in1DstValid,
  input  logic [REG_W-1:0]          in1Dst,
  input  logic [NUM_SRCS-1:0]       in1SrcValid,
  input  logic [NUM_SRCS*REG_W-1:0] in1Srcs,
  input  logic [CNT_W-1:0]          rdCnt [NUM_RD],
  output logic [REG_W-1:0]          rdIdx [NUM_RD],
  output sbStrobe_t                 strobe,
  output logic                      issue0,
  output logic                      issue1
);

  localparam int DST0_PORT = NUM_SRCS;
  localparam int DST1_PORT = 2 * NUM_SRCS + 1;

  logic [CNT_W-1:0] lat0, lat1;
  logic ready0, ready1, pairOk, pairDep;

  assign lat0 = classLatency(in0Class);
  assign lat1 = classLatency(in1Class);

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_idx
    assign rdIdx[s]                = in0Srcs[s*REG_W +: REG_W];
    assign rdIdx[NUM_SRCS + 1 + s] = in1Srcs[s*REG_W +: REG_W];
  end
  assign rdIdx[DST0_PORT] = in0Dst;
  assign rdIdx[DST1_PORT] = in1Dst;

  always_comb begin
    ready0 = in0Valid;
    ready1 = in1Valid;
    pairDep = in0DstValid && in1DstValid && (in0Dst == in1Dst);
    for (int s = 0; s < NUM_SRCS; s++) begin
      if (in0SrcValid[s] && rdCnt[s] != '0) ready0 = 1'b0;
      if (in1SrcValid[s] && rdCnt[NUM_SRCS + 1 + s] != '0) ready1 = 1'b0;
      if (in1SrcValid[s] && in0DstValid &&
          in1Srcs[s*REG_W +: REG_W] == in0Dst) pairDep = 1'b1;
    end
    // a new writer must finish strictly after the pending one
    if (in0DstValid && rdCnt[DST0_PORT] >= lat0) ready0 = 1'b0;
    if (in1DstValid && rdCnt[DST1_PORT] >= lat1) ready1 = 1'b0;
  end

  assign pairOk = isEvenPipe(in0Class) && !isEvenPipe(in1Class);
  assign issue0 = !rst && ready0;
  assign issue1 = issue0 && ready1 && pairOk && !pairDep;

  assign strobe.load0 = issue0 && in0DstValid;
  assign strobe.init0 = lat0 - CNT_W'(1);
  assign strobe.load1 = issue1 && in1DstValid;
  assign strobe.init1 = lat1 - CNT_W'(1);

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_sb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int NUM_RD  = 2 * (NUM_SRCS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in0Valid,
  input  logic [CLS_W-1:0]          in0Class,
  input  logic                      in0DstValid,
  input  logic [REG_W-1:0]          in0Dst,
  input  logic [NUM_SRCS-1:0]       in0SrcValid,
  input  logic [NUM_SRCS*REG_W-1:0] in0Srcs,
  input  logic                      in1Valid,
  input  logic [CLS_W-1:0]          in1Class,
  input  logic                      in1DstValid,
  input  logic [REG_W-1:0]          in1Dst,
  input  logic [NUM_SRCS-1:0]       in1SrcValid,
  input  logic [NUM_SRCS*REG_W-1:0] in1Srcs,
  output logic                      issue0,
  output logic                      issue1
);

  sbStrobe_t        strobe;
  logic [REG_W-1:0] rdIdx [NUM_RD];
  logic [CNT_W-1:0] rdCnt [NUM_RD];

  sb_issue_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .rst(rst),
    .in0Valid(in0Valid), .in0Class(in0Class), .in0DstValid(in0DstValid),
    .in0Dst(in0Dst), .in0SrcValid(in0SrcValid), .in0Srcs(in0Srcs),
    .in1Valid(in1Valid), .in1Class(in1Class), .in1DstValid(in1DstValid),
    .in1Dst(in1Dst), .in1SrcValid(in1SrcValid), .in1Srcs(in1Srcs),
    .rdCnt(rdCnt), .rdIdx(rdIdx), .strobe(strobe),
    .issue0(issue0), .issue1(issue1)
  );

  sb_countdown #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_cnt (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wrIdx0(in0Dst), .wrIdx1(in1Dst),
    .rdIdx(rdIdx), .rdCnt(rdCnt)
  );

endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk
  import issue_sb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in0Valid,
  input logic [CLS_W-1:0]          in0Class,
  input logic                      in0DstValid,
  input logic [REG_W-1:0]          in0Dst,
  input logic [NUM_SRCS-1:0]       in0SrcValid,
  input logic [NUM_SRCS*REG_W-1:0] in0Srcs,
  input logic                      in1Class_unused_guard,
  input logic [CLS_W-1:0]          in1Class,
  input logic                      in1DstValid,
  input logic [REG_W-1:0]          in1Dst,
  input logic [NUM_SRCS-1:0]       in1SrcValid,
  input logic [NUM_SRCS*REG_W-1:0] in1Srcs,
  input logic                      issue0,
  input logic                      issue1
);

  logic             prevWrote;
  logic [REG_W-1:0] prevDst;
  logic [CNT_W-1:0] prevLat;
  logic             rawHit, pairHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWrote <= 1'b0;
      prevDst   <= '0;
      prevLat   <= '0;
    end else begin
      prevWrote <= issue0 && in0DstValid;
      prevDst   <= in0Dst;
      prevLat   <= classLatency(in0Class);
    end
  end

  always_comb begin
    rawHit  = 1'b0;
    pairHit = in0DstValid && in1DstValid && in0Dst == in1Dst;
    for (int s = 0; s < NUM_SRCS; s++) begin
      if (in0SrcValid[s] && in0Srcs[s*REG_W +: REG_W] == prevDst) rawHit = 1'b1;
      if (in1SrcValid[s] && in0DstValid && in1Srcs[s*REG_W +: REG_W] == in0Dst) pairHit = 1'b1;
    end
  end

  always_comb begin
    if (rst) AST_RESET_QUIET: assert (!issue0 && !issue1); // R1
  end

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> issue0); // R2

  AST_NO_EMPTY_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue0 |-> in0Valid); // R2

  AST_PAIR_PIPES: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> (isEvenPipe(in0Class) && !isEvenPipe(in1Class))); // R5

  AST_PAIR_INDEP: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> !pairHit); // R6

  AST_RAW_GAP: assert property (@(posedge clk) disable iff (rst)
    (issue0 && prevWrote) |-> !rawHit); // R4

  AST_WAW_ORDER: assert property (@(posedge clk) disable iff (rst)
    (issue0 && in0DstValid && prevWrote && in0Dst == prevDst)
      |-> (classLatency(in0Class) >= prevLat)); // R8

endmodule

bind issue_scoreboard issue_scoreboard_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst),
  .in0Valid(in0Valid), .in0Class(in0Class), .in0DstValid(in0DstValid),
  .in0Dst(in0Dst), .in0SrcValid(in0SrcValid), .in0Srcs(in0Srcs),
  .in1Class_unused_guard(in1Valid),
  .in1Class(in1Class), .in1DstValid(in1DstValid),
  .in1Dst(in1Dst), .in1SrcValid(in1SrcValid), .in1Srcs(in1Srcs),
  .issue0(issue0), .issue1(issue1)
);

// File: tb/tb_issue_scoreboard.sv
module tb_issue_scoreboard;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in0Valid = 0, in0DstValid = 0, in1Valid = 0, in1DstValid = 0;
  logic [2:0] in0Class = 0, in1Class = 0;
  logic [6:0] in0Dst = 0, in1Dst = 0;
  logic [2:0] in0SrcValid = 0, in1SrcValid = 0;
  logic [20:0] in0Srcs = 0, in1Srcs = 0;
  logic issue0, issue1;

  int checks = 0;
  int fails = 0;
  int model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_scoreboard dut (
    .clk(clk), .rst(rst),
    .in0Valid(in0Valid), .in0Class(in0Class), .in0DstValid(in0DstValid),
    .in0Dst(in0Dst), .in0SrcValid(in0SrcValid), .in0Srcs(in0Srcs),
    .in1Valid(in1Valid), .in1Class(in1Class), .in1DstValid(in1DstValid),
    .in1Dst(in1Dst), .in1SrcValid(in1SrcValid), .in1Srcs(in1Srcs),
    .issue0(issue0), .issue1(issue1)
  );

  function automatic int latOf(input int c);
    case (c)
      1, 3: latOf = 6;
      2:    latOf = 4;
      default: latOf = 2;
    endcase
  endfunction

  function automatic bit evenOf(input int c);
    evenOf = (c == 0) || (c == 1);
  endfunction

  function automatic int srcOf(input logic [20:0] v, input int k);
    srcOf = int'(v[k*7 +: 7]);
  endfunction

  task automatic setSlot(input int slot, input bit v, input int c, input bit dv, input int d,
                         input logic [2:0] sv, input int s0, input int s1, input int s2);
    logic [20:0] packed3;
    packed3 = {7'(s2), 7'(s1), 7'(s0)};
    if (slot == 0) begin
      in0Valid = v; in0Class = 3'(c); in0DstValid = dv; in0Dst = 7'(d);
      in0SrcValid = sv; in0Srcs = packed3;
    end else begin
      in1Valid = v; in1Class = 3'(c); in1DstValid = dv; in1Dst = 7'(d);
      in1SrcValid = sv; in1Srcs = packed3;
    end
  endtask

  task automatic idle();
    setSlot(0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    setSlot(1, 0, 0, 0, 0, 3'b000, 0, 0, 0);
  endtask

  // one cycle: compare grants to the model, then advance the model
  task automatic step(input string tag);
    bit r0, r1, dep, e0, e1;
    @(negedge clk);
    #2;
    r0 = in0Valid;
    r1 = in1Valid;
    dep = in0DstValid && in1DstValid && (in0Dst == in1Dst);
    for (int k = 0; k < 3; k++) begin
      if (in0SrcValid[k] && model[srcOf(in0Srcs, k)] > 0) r0 = 0;
      if (in1SrcValid[k] && model[srcOf(in1Srcs, k)] > 0) r1 = 0;
      if (in1SrcValid[k] && in0DstValid && srcOf(in1Srcs, k) == int'(in0Dst)) dep = 1;
    end
    if (in0DstValid && model[in0Dst] >= latOf(in0Class)) r0 = 0;
    if (in1DstValid && model[in1Dst] >= latOf(in1Class)) r1 = 0;
    e0 = !rst && r0;
    e1 = e0 && r1 && evenOf(in0Class) && !evenOf(in1Class) && !dep;
    checks++;
    if (issue0 !== e0 || issue1 !== e1) begin
      fails++;
      $display("FAIL %s: issue0/issue1 = %b/%b, expected %b/%b", tag, issue0, issue1, e0, e1);
    end
    @(posedge clk);
    #1;
    if (rst) begin
      for (int r = 0; r < NREG; r++) model[r] = 0;
    end else begin
      for (int r = 0; r < NREG; r++) if (model[r] > 0) model[r]--;
      if (e0 && in0DstValid) model[in0Dst] = latOf(in0Class) - 1;
      if (e1 && in1DstValid) model[in1Dst] = latOf(in1Class) - 1;
    end
  endtask

  task automatic drain();
    idle();
    repeat (7) step("drain R2");
  endtask

  // producer of class c into reg d, then a dependent held in slot 0
  task automatic rawCase(input int c, input int d, input string tag);
    setSlot(0, 1, c, 1, d, 3'b000, 0, 0, 0);
    setSlot(1, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    step(tag);
    setSlot(0, 1, 0, 0, 0, 3'b010, 90, d, 91);
    repeat (7) step(tag);
    drain();
  endtask

  task automatic pairCase(input int c0, input int c1, input string tag);
    setSlot(0, 1, c0, 1, 20, 3'b001, 30, 0, 0);
    setSlot(1, 1, c1, 1, 21, 3'b001, 31, 0, 0);
    step(tag);
    drain();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    for (int r = 0; r < NREG; r++) model[r] = 0;
    // R1: grants held low under reset even for a ready instruction
    setSlot(0, 1, 0, 1, 1, 3'b111, 2, 3, 4);
    setSlot(1, 1, 3, 1, 5, 3'b000, 0, 0, 0);
    step("R1 reset quiet");
    step("R1 reset quiet");
    rst = 1'b0;
    step("R1 all ready after reset");
    drain();

    // R4 latency per class, R3 class codes
    rawCase(0, 5, "R4 fixed point gap");
    rawCase(2, 6, "R4 permute gap");
    rawCase(3, 7, "R4 load/store gap");
    rawCase(1, 8, "R4 floating gap");
    rawCase(4, 9, "R3 branch code");
    rawCase(7, 10, "R3 undefined code as channel");

    // R5 pipe pairing
    pairCase(0, 3, "R5 fix+ldst dual");
    pairCase(1, 2, "R5 flt+perm dual");
    pairCase(3, 0, "R5 odd then even");
    pairCase(0, 1, "R5 two even");
    pairCase(2, 3, "R5 two odd");
    pairCase(1, 5, "R3 flt+chan dual");

    // R6 dependence inside the pair
    setSlot(0, 1, 0, 1, 40, 3'b000, 0, 0, 0);
    setSlot(1, 1, 3, 0, 0, 3'b100, 0, 0, 40);
    step("R6 slot1 reads slot0 dst");
    drain();
    setSlot(0, 1, 0, 1, 41, 3'b000, 0, 0, 0);
    setSlot(1, 1, 2, 1, 41, 3'b000, 0, 0, 0);
    step("R6 same destination");
    drain();

    // R7 older stall holds younger
    setSlot(0, 1, 3, 1, 12, 3'b000, 0, 0, 0);
    setSlot(1, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    step("R7 producer");
    setSlot(0, 1, 0, 0, 0, 3'b001, 12, 0, 0);
    setSlot(1, 1, 3, 1, 50, 3'b000, 0, 0, 0);
    repeat (7) step("R7 younger held");
    drain();

    // R8 write ordering
    setSlot(0, 1, 1, 1, 3, 3'b000, 0, 0, 0);
    setSlot(1, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    step("R8 slow writer");
    setSlot(0, 1, 0, 1, 3, 3'b000, 0, 0, 0);
    repeat (7) step("R8 fast writer waits");
    drain();
    setSlot(0, 1, 0, 1, 4, 3'b000, 0, 0, 0);
    step("R8 fast writer");
    setSlot(0, 1, 1, 1, 4, 3'b000, 0, 0, 0);
    repeat (3) step("R8 slow writer follows");
    drain();

    // R9 invalid sources and destinations
    setSlot(0, 1, 3, 1, 60, 3'b000, 0, 0, 0);
    step("R9 producer");
    setSlot(0, 1, 0, 0, 60, 3'b000, 60, 60, 60);
    setSlot(1, 1, 3, 0, 60, 3'b000, 60, 60, 60);
    step("R9 invalid operands ignored");
    setSlot(0, 1, 0, 0, 61, 3'b000, 0, 0, 0);
    setSlot(1, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    step("R9 no dst write");
    setSlot(0, 1, 0, 0, 0, 3'b001, 61, 0, 0);
    step("R9 reg untouched");
    drain();

    // R2 empty older slot
    setSlot(0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    setSlot(1, 1, 3, 1, 70, 3'b000, 0, 0, 0);
    step("R2 slot0 empty");
    drain();

    // mixed traffic over a few registers
    for (int n = 0; n < 4000; n++) begin
      setSlot(0, ($urandom % 8) != 0, $urandom % 8, $urandom % 2, $urandom % 8,
              3'($urandom), $urandom % 8, $urandom % 8, $urandom % 8);
      setSlot(1, ($urandom % 4) != 0, $urandom % 8, $urandom % 2, $urandom % 8,
              3'($urandom), $urandom % 8, $urandom % 8, $urandom % 8);
      step("mixed R4 R5 R6 R7 R8");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule